// File: doc/BRIEF.md
# Scan Flip-Flop with Input-Stability Monitor

This block is a multi-bit mux-scan register with an on-line check on its input path. A scan-enable picks either the functional data word or the scan test word. That selected word is captured on the rising edge of a capture clock. At the same time, a monitor running on a fast sampling clock watches each selected bit during a check window. The window is a pulse that spans the capture edge and covers the setup-plus-hold interval.

For every bit, the monitor forms a two-rail pair from two copies of the selected bit:
- the true copy, and
- an inverted copy delayed by a configurable number of fast-clock cycles, standing in for the selector's propagation delay.

A bit that holds steady gives complementary rails. A bit that moves late, or pulses, while the window is open briefly makes the rails equal. The monitor latches that event per bit as the error pair (1,1). The pair stays there until the active-low reset clears it to (0,1). Because the window contains the capture edge, the error indication is valid in the same capture period as the datum it qualifies.

Top module: `scan_ff_monitor`

## Requirements
- R1: While `rst_ni` is low, `q_o` is 0 and every error pair reads `err_t_o[b]=0`, `err_c_o[b]=1`.
- R2: On each rising edge of `clk_cap_i`, `q_o` takes `d_i` when `se_i=0` and `ti_i` when `se_i=1`.
- R3: The monitor observes only the selected word. Toggling a bit of the unselected word while the window is high leaves that bit's pair at (0,1).
- R4: A selected bit held constant for the whole window leaves its pair at (0,1).
- R5: If a selected bit changes while `win_i` is high, and `win_i` is still high at the next rising edge of `clk_mon_i`, that bit's pair reads (1,1) after that edge.
- R6: Changes of a selected bit while `win_i` is low never raise an error. This holds provided at least `MUX_DLY` monitor-clock rising edges pass between the change and the first rising edge with `win_i` high.
- R7: Once a pair reads (1,1), it stays (1,1) after the input settles and after the window closes, until reset.
- R8: Driving `rst_ni` low clears every pair to (0,1) at once, overriding any detection in the same cycle.
- R9: Bits are monitored independently. An event on bit b changes only pair b.
- R10: Each pair only ever reads (0,1) or (1,1); `err_c_o` stays 1 for every bit.
- R11: A pulse on a selected bit lasting one monitor-clock cycle inside the window sets that bit's pair to (1,1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cap_i | input | 1 | Capture clock for the datum register (rising edge) |
| clk_mon_i | input | 1 | Fast monitor sampling clock (rising edge) |
| rst_ni | input | 1 | Active-low asynchronous reset for both clock domains |
| se_i | input | 1 | Scan-enable: 0 selects `d_i`, 1 selects `ti_i` |
| d_i | input | WIDTH | Functional data word |
| ti_i | input | WIDTH | Scan test word |
| win_i | input | 1 | Check window, high around the capture edge |
| q_o | output | WIDTH | Captured datum |
| err_t_o | output | WIDTH | True rail of each bit's latched error pair |
| err_c_o | output | WIDTH | Second rail of each bit's latched error pair |

## Verification
The datum is due at the capture-clock rising edge. Each error pair is due one monitor-clock rising edge after an in-window change, since the latch samples the rails on that edge. The bench drives every input and takes every sample on falling edges of the monitor clock, so each result has at least half a cycle to settle. Outcomes are read only after the window has closed and two more falling edges have passed. The out-of-window case moves the input two monitor edges before the window opens, which meets the `MUX_DLY` margin of R6. Stickiness is read again several cycles later, after a further out-of-window toggle.

// File: rtl/sff_pkg.sv
package sff_pkg;

  typedef struct packed {
    logic t;
    logic c;
  } rail_pair_t;

  localparam rail_pair_t PAIR_CLEAR = '{t: 1'b0, c: 1'b1};
  localparam rail_pair_t PAIR_FAULT = '{t: 1'b1, c: 1'b1};

endpackage

// File: rtl/sff_input_sel.sv
module sff_input_sel #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned MUX_DLY = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             se_i,
  input  logic [WIDTH-1:0] d_i,
  input  logic [WIDTH-1:0] ti_i,
  output logic [WIDTH-1:0] sel_o,
  output logic [WIDTH-1:0] comp_o
);

  localparam int unsigned LAST = MUX_DLY - 1;

  logic [WIDTH-1:0] sel;
  logic [WIDTH-1:0] chain_q [MUX_DLY];

  assign sel = se_i ? ti_i : d_i;

  // inverted copy lags the true copy by MUX_DLY monitor cycles
  for (genvar s = 0; s < MUX_DLY; s++) begin : g_dly
    if (s == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= '1;
        else         chain_q[s] <= ~sel;
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= '1;
        else         chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign sel_o  = sel;
  assign comp_o = chain_q[LAST];

  // R3: first stage follows the selected input, not the other word
  a_r3_stage_tracks_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> chain_q[0] == ~$past(se_i ? ti_i : d_i));

endmodule

// File: rtl/sff_rail_check.sv
module sff_rail_check
  import sff_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       win_i,
  input  logic       true_i,
  input  logic       comp_i,
  output rail_pair_t pair_o
);

  logic       noncode;
  rail_pair_t pair_q;

  // rails equal inside the window: not a two-rail codeword
  assign noncode = win_i && (true_i == comp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pair_q <= PAIR_CLEAR;
    else if (noncode) pair_q <= PAIR_FAULT;
  end

  assign pair_o = pair_q;

  a_r10_pair_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_q.c == 1'b1);

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_q.t |=> pair_q.t);

  a_r5_flag_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_i && (true_i == comp_i)) |=> pair_q.t);

  a_r6_quiet_outside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win_i && !pair_q.t) |=> !pair_q.t);

endmodule

// File: rtl/sff_capture.sv
module sff_capture #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= data_i;
  end

  assign q_o = q_q;

endmodule

// File: rtl/scan_ff_monitor.sv
module scan_ff_monitor
  import sff_pkg::*;
#(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned MUX_DLY = 1
) (
  input  logic             clk_cap_i,
  input  logic             clk_mon_i,
  input  logic             rst_ni,
  input  logic             se_i,
  input  logic [WIDTH-1:0] d_i,
  input  logic [WIDTH-1:0] ti_i,
  input  logic             win_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] err_t_o,
  output logic [WIDTH-1:0] err_c_o
);

  logic [WIDTH-1:0] sel;
  logic [WIDTH-1:0] comp;

  sff_input_sel #(
    .WIDTH  (WIDTH),
    .MUX_DLY(MUX_DLY)
  ) u_sel (
    .clk_i (clk_mon_i),
    .rst_ni(rst_ni),
    .se_i  (se_i),
    .d_i   (d_i),
    .ti_i  (ti_i),
    .sel_o (sel),
    .comp_o(comp)
  );

  sff_capture #(
    .WIDTH(WIDTH)
  ) u_cap (
    .clk_i (clk_cap_i),
    .rst_ni(rst_ni),
    .data_i(sel),
    .q_o   (q_o)
  );

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    rail_pair_t pair;

    sff_rail_check u_chk (
      .clk_i (clk_mon_i),
      .rst_ni(rst_ni),
      .win_i (win_i),
      .true_i(sel[b]),
      .comp_i(comp[b]),
      .pair_o(pair)
    );

    assign err_t_o[b] = pair.t;
    assign err_c_o[b] = pair.c;
  end

endmodule

// File: tb/sim_scan_ff_monitor.sv
`timescale 1ns/1ps
module sim_scan_ff_monitor;

  localparam int W = 4;

  logic         clk_mon = 1'b0;
  logic         clk_cap = 1'b0;
  logic         rst_n   = 1'b0;
  logic         se      = 1'b0;
  logic         win     = 1'b0;
  logic [W-1:0] d       = '0;
  logic [W-1:0] ti      = '0;
  logic [W-1:0] q, et, ec;

  int checks = 0;
  int errs   = 0;

  always #2.5 clk_mon = ~clk_mon;

  scan_ff_monitor #(.WIDTH(W), .MUX_DLY(1)) u0 (
    .clk_cap_i(clk_cap),
    .clk_mon_i(clk_mon),
    .rst_ni   (rst_n),
    .se_i     (se),
    .d_i      (d),
    .ti_i     (ti),
    .win_i    (win),
    .q_o      (q),
    .err_t_o  (et),
    .err_c_o  (ec)
  );

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic nedge(int n);
    repeat (n) @(negedge clk_mon);
  endtask

  task automatic flip(bit on_ti, int b);
    if (on_ti) ti[b] = ~ti[b];
    else       d[b]  = ~d[b];
  endtask

  // kind: 0 stable, 1 late change, 2 one-cycle pulse, 3 change before window, 4 unselected toggle
  task automatic run_case(bit s, int b, int k, int seed);
    logic [W-1:0] exp_q, exp_t;
    string tag;
    nedge(1);
    rst_n = 1'b0; win = 1'b0;
    nedge(1);
    chk("R1 q_o in reset", q, '0);
    chk("R1 err_t_o in reset", et, '0);
    chk("R1 err_c_o in reset", ec, '1);
    rst_n = 1'b1;
    d  = W'(seed * 5 + 3);
    ti = W'(~(seed * 3));
    se = s;
    nedge(3);
    if (k == 3) begin flip(s, b); nedge(2); end
    win = 1'b1;
    nedge(1);
    exp_q = s ? ti : d;
    clk_cap = 1'b1;
    nedge(1);
    clk_cap = 1'b0;
    if (k == 1) begin flip(s, b); nedge(1); end
    if (k == 2) begin flip(s, b); nedge(1); flip(s, b); nedge(1); end
    if (k == 4) begin flip(!s, b); nedge(1); end
    nedge(1);
    win = 1'b0;
    nedge(2);
    exp_t = (k == 1 || k == 2) ? (W'(1) << b) : '0;
    case (k)
      0: tag = "R4 stable window";
      1: tag = "R5 R9 late change";
      2: tag = "R11 R9 one-cycle pulse";
      3: tag = "R6 change outside window";
      default: tag = "R3 unselected toggle";
    endcase
    chk("R2 captured datum", q, exp_q);
    chk(tag, et, exp_t);
    chk("R10 second rail held", ec, '1);
    flip(s, (b + 1) % W);
    nedge(5);
    chk("R7 sticky after settle", et, exp_t);
    chk("R6 toggle with window low", et, exp_t);
    rst_n = 1'b0;
    nedge(1);
    chk("R8 reset clears pair t", et, '0);
    chk("R8 reset clears pair c", ec, '1);
    rst_n = 1'b1;
  endtask

  initial begin
    nedge(2);
    chk("R1 initial q_o", q, '0);
    chk("R1 initial err_t_o", et, '0);
    rst_n = 1'b1;
    for (int s = 0; s < 2; s++)
      for (int b = 0; b < W; b++)
        for (int k = 0; k < 5; k++)
          run_case(s[0], b, k, s * 20 + b * 5 + k);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #1000000;
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule